// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Hunt

This block is the receive half of a character-oriented synchronous serial link. It works on the system clock. A one-cycle strobe marks each rising edge of the recovered receive clock, and the data bit that goes with it arrives alongside the strobe. Clock recovery and any processor bus sit outside the block.

A hunt command, or reset, fills the receive window with ones and puts the block into hunt. During hunt, each strobe shifts one bit into the window, and the newest character-length bits are compared against a programmed sync pattern. One-pattern and two-pattern alignment are both available. As an alternative, an external sync level held across two strobes ends the hunt.

Once aligned, the block groups the bits into characters of 5 to 8 bits, least significant bit first. A parity bit may follow each character. The block then presents each character with a ready flag. It flags parity and overrun errors without stopping, and it raises a sticky sync flag whenever a received character equals the first sync pattern.

Top module: `syncrx_top`

## Requirements
- R1: After reset or a hunt command, `in_hunt`=1 and `sync_flag`=0, and the receive window holds all ones. With a 5-bit all-ones sync pattern, a single received 1 bit is therefore enough to achieve alignment.
- R2: In hunt, each `bit_en` strobe shifts `rx_bit` in. The window's newest character is compared with the sync pattern at every strobe. On a match, `in_hunt` falls and `sync_flag` rises at the clock edge that takes the last matching bit.
- R3: Character length is `len_code`+5 bits (code 0 gives 5 bits, code 3 gives 8). Only that many low bits of `sync_a` and `sync_b` take part in any comparison, and the upper bits have no effect.
- R4: When `par_en`=1, each frame ends with one parity bit after the character. During hunt, that bit is left out of the match, and the match is judged only once the parity bit itself has arrived. No parity error is ever flagged during hunt.
- R5: When `dual_sync`=1, the hunt ends only when `sync_a` is matched and `sync_b` is then matched in the very next frame. If the second frame fails but equals `sync_a`, the block waits for another second frame. Any other value returns it to single-bit search.
- R6: When `ext_mode`=1, internal pattern matching is off. The hunt ends at the strobe where `ext_sync_in` is high and was also high at the previous strobe since the hunt began.
- R7: After alignment, every frame of length+parity bits loads the character into `rx_char` (zero-extended, LSB received first) and sets `rx_ready`. A `data_rd` pulse clears `rx_ready`.
- R8: With `par_en`=1, a character whose parity bit does not give the selected sense sets `parity_err`. The sense is even when `par_odd`=0 and odd when `par_odd`=1. The flag is sticky and `err_clr` clears it.
- R9: A character that completes while `rx_ready` is still set raises `overrun_err` and replaces `rx_char`. The flag is sticky and `err_clr` clears it.
- R10: After alignment, a received character equal to the masked `sync_a` sets `sync_flag`. A `status_rd` pulse clears it.
- R11: In external mode after alignment, `ext_sync_in` low at one strobe and then high at the next two strobes sets `sync_flag`.
- R12: A hunt command in any state drops alignment at once and discards a partly received character. `in_hunt` goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per receive-clock rising edge |
| rx_bit | input | 1 | Serial data bit taken with the strobe |
| hunt_cmd | input | 1 | Pulse: restart the hunt |
| status_rd | input | 1 | Pulse: status read, clears sync flag |
| data_rd | input | 1 | Pulse: character read, clears ready |
| err_clr | input | 1 | Pulse: clears parity and overrun flags |
| len_code | input | 2 | Character length minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity |
| dual_sync | input | 1 | Two-pattern alignment |
| ext_mode | input | 1 | External sync alignment |
| ext_sync_in | input | 1 | External sync level |
| sync_a | input | 8 | First sync pattern |
| sync_b | input | 8 | Second sync pattern |
| in_hunt | output | 1 | Block is hunting for alignment |
| sync_flag | output | 1 | Sticky sync status |
| rx_char | output | 8 | Last received character |
| rx_ready | output | 1 | Character waiting to be read |
| parity_err | output | 1 | Sticky parity error |
| overrun_err | output | 1 | Sticky overrun error |

## Verification
The hardest case to reach is a near miss in two-pattern hunt. This happens when the first pattern matches, or slides into a match because the window was preset to ones, but the following frame does not carry the second pattern. It also happens when a pattern matches one bit earlier than the sender intended. The bench reaches these cases by sweeping every sync value for every length and parity setting, with junk in the unused upper bits. A bit-level model derived from the requirements predicts the exact strobe of alignment and every later frame boundary. Directed sequences then feed a failed second frame, an external level that is high for only one strobe, and a hunt command in the middle of a character.

// File: rtl/syncrx_pkg.sv
// Shared types for the synchronous receiver.
package syncrx_pkg;
    // Alignment sequencer states
    typedef enum logic [1:0] {
        HS_SEEK   = 2'd0,   // sliding search for the first pattern
        HS_SECOND = 2'd1,   // first pattern seen, waiting one frame
        HS_LOCKED = 2'd2    // character alignment held
    } hunt_state_t;
endpackage

// File: rtl/syncrx_window.sv
// Receive window: a shift register one frame wide (character plus parity).
// New bits enter at the top, so the newest frame always sits at the top.
// The outputs show the frame as it will be after the current strobe's shift,
// so that consumers can act on the same edge. Assumes frame_len <= W.
module syncrx_window #(
    parameter int MAX_BITS = 8,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                preset,
    input  logic                bit_en,
    input  logic                rx_bit,
    input  logic [CNT_W-1:0]    n_bits,
    input  logic [CNT_W-1:0]    frame_len,
    input  logic [MAX_BITS-1:0] char_mask,
    output logic [MAX_BITS-1:0] char_now,
    output logic                par_now
);
    localparam int W = MAX_BITS + 1;

    logic [W-1:0]     win;
    logic [W-1:0]     nxt;
    logic [W-1:0]     frame;
    logic [CNT_W-1:0] shamt;

    // Purpose: window contents after this cycle's shift, aligned to bit 0
    always_comb begin
        nxt      = bit_en ? {rx_bit, win[W-1:1]} : win;
        shamt    = CNT_W'(W) - frame_len;
        frame    = nxt >> shamt;
        char_now = frame[MAX_BITS-1:0] & char_mask;
        par_now  = frame[n_bits];
    end

    // Purpose: hold the window, preset to all ones on reset or hunt
    always_ff @(posedge clk) begin
        if (!rst_n || preset)
            win <= '1;
        else if (bit_en)
            win <= nxt;
    end

    assert_preset_all_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (win == '1));
endmodule

// File: rtl/syncrx_hunt.sv
// Alignment sequencer and sync status flag.
// Runs either an internal one- or two-pattern search, or an external
// level-based search. Its output tells the assembler when frames are aligned.
// Assumes masked sync patterns and one strobe per received bit.
module syncrx_hunt
    import syncrx_pkg::*;
#(
    parameter int MAX_BITS = 8,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hunt_cmd,
    input  logic                bit_en,
    input  logic                status_rd,
    input  logic                ext_mode,
    input  logic                dual_sync,
    input  logic                ext_sync_in,
    input  logic [CNT_W-1:0]    frame_len,
    input  logic [MAX_BITS-1:0] char_now,
    input  logic [MAX_BITS-1:0] sync_a_m,
    input  logic [MAX_BITS-1:0] sync_b_m,
    input  logic                char_hit,
    output logic                locked,
    output logic                sync_flag
);
    hunt_state_t      st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [1:0]       hist;
    logic             hunt_set;
    logic             match_a, match_b, frame_end;
    logic             ext_lock, ext_mark, flag_set;

    // Purpose: pattern compares and external level qualifiers
    always_comb begin
        match_a   = (char_now == sync_a_m);
        match_b   = (char_now == sync_b_m);
        frame_end = ((cnt + CNT_W'(1)) == frame_len);
        ext_lock  = ext_mode && bit_en && ext_sync_in && hist[0];
        ext_mark  = ext_lock && !hist[1];
    end

    // Purpose: next-state logic for the alignment search
    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        hunt_set = 1'b0;
        case (st)
            HS_SEEK: begin
                if (ext_mode) begin
                    if (ext_lock) begin
                        st_n     = HS_LOCKED;
                        hunt_set = 1'b1;
                    end
                end else if (bit_en && match_a) begin
                    cnt_n = '0;
                    if (dual_sync) begin
                        st_n = HS_SECOND;
                    end else begin
                        st_n     = HS_LOCKED;
                        hunt_set = 1'b1;
                    end
                end
            end
            HS_SECOND: begin
                if (ext_mode) begin
                    st_n = HS_SEEK;
                end else if (bit_en) begin
                    if (frame_end) begin
                        cnt_n = '0;
                        if (match_b) begin
                            st_n     = HS_LOCKED;
                            hunt_set = 1'b1;
                        end else if (!match_a) begin
                            st_n = HS_SEEK;
                        end
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
            end
            HS_LOCKED: ;
            default: st_n = HS_SEEK;
        endcase
        if (hunt_cmd) begin
            st_n  = HS_SEEK;
            cnt_n = '0;
        end
    end

    assign flag_set = !hunt_cmd &&
                      (hunt_set || ((st == HS_LOCKED) && (char_hit || ext_mark)));

    // Purpose: state, frame counter and external level history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= HS_SEEK;
            cnt  <= '0;
            hist <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (hunt_cmd)
                hist <= '0;
            else if (bit_en)
                hist <= {hist[0], ext_sync_in};
        end
    end

    // Purpose: sticky sync status, set wins over read, hunt clears
    always_ff @(posedge clk) begin
        if (!rst_n || hunt_cmd)
            sync_flag <= 1'b0;
        else if (flag_set)
            sync_flag <= 1'b1;
        else if (status_rd)
            sync_flag <= 1'b0;
    end

    assign locked = (st == HS_LOCKED);

    assert_lock_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(bit_en));

    assert_read_clears_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !bit_en) |=> !sync_flag);

    assert_hunt_drops_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> !locked);
endmodule

// File: rtl/syncrx_assembler.sv
// Character assembler: counts frame bits once aligned, loads the character,
// checks parity and keeps the sticky error flags. Also reports a received
// character that equals the first sync pattern. Assumes frames of frame_len bits.
module syncrx_assembler #(
    parameter int MAX_BITS = 8,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hunt_cmd,
    input  logic                locked,
    input  logic                bit_en,
    input  logic [CNT_W-1:0]    frame_len,
    input  logic [MAX_BITS-1:0] char_now,
    input  logic                par_now,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic [MAX_BITS-1:0] sync_a_m,
    input  logic                data_rd,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] rx_char,
    output logic                rx_ready,
    output logic                parity_err,
    output logic                overrun_err,
    output logic                char_hit
);
    logic [CNT_W-1:0] bit_cnt;
    logic             done, par_bad;

    // Purpose: frame completion, parity judgement and sync compare
    always_comb begin
        done     = locked && bit_en && !hunt_cmd &&
                   ((bit_cnt + CNT_W'(1)) == frame_len);
        par_bad  = ((^char_now) ^ par_now) != par_odd;
        char_hit = done && (char_now == sync_a_m);
    end

    // Purpose: bit position within the current frame
    always_ff @(posedge clk) begin
        if (!rst_n || hunt_cmd || !locked)
            bit_cnt <= '0;
        else if (bit_en)
            bit_cnt <= done ? '0 : bit_cnt + CNT_W'(1);
    end

    // Purpose: character hold register and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_char  <= '0;
            rx_ready <= 1'b0;
        end else begin
            if (done)
                rx_char <= char_now;
            if (done)
                rx_ready <= 1'b1;
            else if (data_rd)
                rx_ready <= 1'b0;
        end
    end

    // Purpose: sticky error flags, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_err  <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            if (done && par_en && par_bad)
                parity_err <= 1'b1;
            else if (err_clr)
                parity_err <= 1'b0;
            if (done && rx_ready && !data_rd)
                overrun_err <= 1'b1;
            else if (err_clr)
                overrun_err <= 1'b0;
        end
    end

    assert_ready_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> ($past(bit_en) && $past(locked)));

    assert_overrun_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> $past(rx_ready));

    assert_no_parity_in_hunt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> $past(locked));
endmodule

// File: rtl/syncrx_top.sv
// Synchronous character receiver top: decodes the character format and
// masks the sync patterns, then connects the window, the alignment
// sequencer and the assembler. Assumes one bit_en strobe per received bit.
module syncrx_top #(
    parameter int MIN_BITS = 5,
    parameter int MAX_BITS = 8,
    parameter int LEN_W    = $clog2(MAX_BITS - MIN_BITS + 1),
    parameter int CNT_W    = $clog2(MAX_BITS + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                rx_bit,
    input  logic                hunt_cmd,
    input  logic                status_rd,
    input  logic                data_rd,
    input  logic                err_clr,
    input  logic [LEN_W-1:0]    len_code,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                dual_sync,
    input  logic                ext_mode,
    input  logic                ext_sync_in,
    input  logic [MAX_BITS-1:0] sync_a,
    input  logic [MAX_BITS-1:0] sync_b,
    output logic                in_hunt,
    output logic                sync_flag,
    output logic [MAX_BITS-1:0] rx_char,
    output logic                rx_ready,
    output logic                parity_err,
    output logic                overrun_err
);
    logic [CNT_W-1:0]    n_bits, frame_len;
    logic [MAX_BITS-1:0] char_mask, sync_a_m, sync_b_m, char_now;
    logic                par_now, locked, char_hit;

    // Purpose: character length, frame length and the valid-bit mask
    always_comb begin
        n_bits    = CNT_W'(MIN_BITS) + CNT_W'(len_code);
        frame_len = n_bits + CNT_W'(par_en);
        for (int i = 0; i < MAX_BITS; i++)
            char_mask[i] = (CNT_W'(i) < n_bits);
        sync_a_m  = sync_a & char_mask;
        sync_b_m  = sync_b & char_mask;
    end

    syncrx_window #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_window (
        .clk(clk), .rst_n(rst_n), .preset(hunt_cmd), .bit_en(bit_en),
        .rx_bit(rx_bit), .n_bits(n_bits), .frame_len(frame_len),
        .char_mask(char_mask), .char_now(char_now), .par_now(par_now)
    );

    syncrx_hunt #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_hunt (
        .clk(clk), .rst_n(rst_n), .hunt_cmd(hunt_cmd), .bit_en(bit_en),
        .status_rd(status_rd), .ext_mode(ext_mode), .dual_sync(dual_sync),
        .ext_sync_in(ext_sync_in), .frame_len(frame_len), .char_now(char_now),
        .sync_a_m(sync_a_m), .sync_b_m(sync_b_m), .char_hit(char_hit),
        .locked(locked), .sync_flag(sync_flag)
    );

    syncrx_assembler #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .hunt_cmd(hunt_cmd), .locked(locked),
        .bit_en(bit_en), .frame_len(frame_len), .char_now(char_now),
        .par_now(par_now), .par_en(par_en), .par_odd(par_odd),
        .sync_a_m(sync_a_m), .data_rd(data_rd), .err_clr(err_clr),
        .rx_char(rx_char), .rx_ready(rx_ready), .parity_err(parity_err),
        .overrun_err(overrun_err), .char_hit(char_hit)
    );

    assign in_hunt = !locked;

    assert_ready_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !data_rd && !hunt_cmd) |=> rx_ready);
endmodule

// File: tb/syncrx_top_test.sv
`timescale 1ns/1ps
module syncrx_top_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       bit_en = 0, rx_bit = 0, hunt_cmd = 0, status_rd = 0;
    logic       data_rd = 0, err_clr = 0;
    logic [1:0] len_code = 0;
    logic       par_en = 0, par_odd = 0, dual_sync = 0, ext_mode = 0, ext_sync_in = 0;
    logic [7:0] sync_a = 0, sync_b = 0;
    logic       in_hunt, sync_flag, rx_ready, parity_err, overrun_err;
    logic [7:0] rx_char;

    int total = 0, bad = 0;
    bit finished = 0;

    // bench model state, derived from the requirements
    int m_n, m_fl, m_mask, m_sa, m_sb, m_st, m_cnt, m_w, m_hist;
    int e_char;
    bit e_flag, e_ready, e_pe, e_ov;

    syncrx_top uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .hunt_cmd(hunt_cmd), .status_rd(status_rd), .data_rd(data_rd),
        .err_clr(err_clr), .len_code(len_code), .par_en(par_en),
        .par_odd(par_odd), .dual_sync(dual_sync), .ext_mode(ext_mode),
        .ext_sync_in(ext_sync_in), .sync_a(sync_a), .sync_b(sync_b),
        .in_hunt(in_hunt), .sync_flag(sync_flag), .rx_char(rx_char),
        .rx_ready(rx_ready), .parity_err(parity_err), .overrun_err(overrun_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic set_cfg(input int code, input bit par, input bit odd,
                           input bit dual, input bit ext, input int sa, input int sb);
        len_code = 2'(code); par_en = par; par_odd = odd;
        dual_sync = dual; ext_mode = ext;
        sync_a = 8'(sa); sync_b = 8'(sb);
        m_n = code + 5; m_fl = m_n + int'(par);
        m_mask = (1 << m_n) - 1;
        m_sa = sa & m_mask; m_sb = sb & m_mask;
    endtask

    task automatic model_hunt();
        m_st = 0; m_cnt = 0; m_w = (1 << m_fl) - 1; m_hist = 0; e_flag = 0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2 in_hunt"}, int'(in_hunt), int'(m_st != 2));
        chk({tag, " R10 sync_flag"}, int'(sync_flag), int'(e_flag));
        chk({tag, " R7 ready"}, int'(rx_ready), int'(e_ready));
        if (e_ready) chk({tag, " R7 char"}, int'(rx_char), e_char);
        chk({tag, " R8 parity_err"}, int'(parity_err), int'(e_pe));
        chk({tag, " R9 overrun"}, int'(overrun_err), int'(e_ov));
    endtask

    task automatic send_bit(input int b);
        int ch, pb;
        @(negedge clk);
        rx_bit = b[0]; bit_en = 1;
        @(negedge clk);
        bit_en = 0;
        m_w = ((m_w >> 1) | ((b & 1) << (m_fl - 1))) & ((1 << m_fl) - 1);
        ch = m_w & m_mask;
        pb = (m_w >> m_n) & 1;
        if (m_st == 0) begin
            if (ext_mode) begin
                if (ext_sync_in && (m_hist & 1)) begin m_st = 2; m_cnt = 0; e_flag = 1; end
            end else if (ch == m_sa) begin
                m_cnt = 0;
                if (dual_sync) m_st = 1; else begin m_st = 2; e_flag = 1; end
            end
        end else if (m_st == 1) begin
            m_cnt++;
            if (m_cnt == m_fl) begin
                m_cnt = 0;
                if (ch == m_sb) begin m_st = 2; e_flag = 1; end
                else if (ch != m_sa) m_st = 0;
            end
        end else begin
            if (ext_mode && ext_sync_in && (m_hist == 1)) e_flag = 1;
            m_cnt++;
            if (m_cnt == m_fl) begin
                m_cnt = 0;
                if (e_ready) e_ov = 1;
                e_ready = 1; e_char = ch;
                if (par_en && ((($countones(ch) + pb) % 2) != int'(par_odd))) e_pe = 1;
                if (ch == m_sa) e_flag = 1;
            end
        end
        m_hist = ((m_hist << 1) | int'(ext_sync_in)) & 3;
        check_all("bit");
    endtask

    task automatic send_char(input int d, input int pbit);
        for (int i = 0; i < m_n; i++) send_bit((d >> i) & 1);
        if (par_en) send_bit(pbit);
    endtask

    function automatic int good_par(input int d);
        return ($countones(d & m_mask) + int'(par_odd)) % 2;
    endfunction

    task automatic do_hunt();
        @(negedge clk); hunt_cmd = 1; @(negedge clk); hunt_cmd = 0;
        model_hunt();
        check_all("hunt R12");
    endtask

    task automatic do_status();
        @(negedge clk); status_rd = 1; @(negedge clk); status_rd = 0;
        e_flag = 0;
    endtask

    task automatic do_read();
        @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
        e_ready = 0;
    endtask

    task automatic do_clr();
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
        e_pe = 0; e_ov = 0;
    endtask

    initial begin
        e_ready = 0; e_pe = 0; e_ov = 0; e_char = 0;
        set_cfg(0, 0, 0, 0, 0, 31, 0);
        model_hunt();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset in_hunt", int'(in_hunt), 1);
        chk("R1 reset sync_flag", int'(sync_flag), 0);
        chk("R1 reset ready", int'(rx_ready), 0);
        chk("R1 reset errors", int'(parity_err) + int'(overrun_err), 0);
        // R1 preset ones: single 1 bit aligns on all-ones 5-bit pattern
        send_bit(1);
        chk("R1 preset single bit lock", int'(in_hunt), 0);
        do_status();

        // Sweep R2 R3 R4 R7 R10: every sync value, each length and parity
        for (int code = 0; code < 4; code++) begin
            for (int par = 0; par < 2; par++) begin
                for (int s = 0; s < (1 << (code + 5)); s++) begin
                    int junk, d;
                    junk = ((~s) << (code + 5)) & 8'hFF;   // R3 upper bits ignored
                    set_cfg(code, par[0], s[0], 0, 0, s | junk, 0);
                    do_read(); do_clr();
                    do_hunt();
                    send_char(s, good_par(s) ^ 1);   // R4 bad parity bit ignored in hunt
                    chk("R2 aligned after pattern", int'(in_hunt), 0);
                    chk("R4 no parity error in hunt", int'(parity_err), 0);
                    do_status();
                    d = (s * 37 + 11) & m_mask;
                    send_char(d, good_par(d));
                    chk("R7 char received", int'(rx_char), e_char);
                end
            end
        end

        // R5 two-pattern hunt with a failed second frame
        set_cfg(0, 0, 0, 1, 0, 8'h0C, 8'h19);
        do_read(); do_clr(); do_hunt();
        send_char(8'h0C, 0);
        chk("R5 first pattern alone keeps hunting", int'(in_hunt), 1);
        send_char(8'h00, 0);
        chk("R5 wrong second frame keeps hunting", int'(in_hunt), 1);
        send_char(8'h0C, 0);
        send_char(8'h19, 0);
        chk("R5 pattern pair aligns", int'(in_hunt), 0);
        chk("R5 sync flag on pair", int'(sync_flag), 1);

        // R6 external alignment, R11 external mark after lock
        set_cfg(3, 0, 0, 0, 1, 8'hA5, 0);
        ext_sync_in = 0;
        do_read(); do_clr(); do_hunt();
        send_char(8'hA5, 0);
        chk("R6 pattern ignored in external mode", int'(in_hunt), 1);
        ext_sync_in = 1;
        send_bit(0);
        chk("R6 one strobe high not enough", int'(in_hunt), 1);
        send_bit(0);
        chk("R6 two strobes high aligns", int'(in_hunt), 0);
        do_status();
        ext_sync_in = 0;
        send_bit(1);
        send_bit(1);
        chk("R11 no mark before rise", int'(sync_flag), 0);
        ext_sync_in = 1;
        send_bit(0);
        send_bit(0);
        chk("R11 external mark sets flag", int'(sync_flag), 1);
        ext_sync_in = 0;

        // R8 parity errors, odd sense then even sense
        set_cfg(2, 1, 1, 0, 0, 8'h2B, 0);
        do_read(); do_clr(); do_hunt();
        send_char(8'h2B, good_par(8'h2B));
        do_status();
        send_char(8'h11, good_par(8'h11) ^ 1);
        chk("R8 odd parity error flagged", int'(parity_err), 1);
        do_read();
        send_char(8'h12, good_par(8'h12));
        chk("R8 flag sticky", int'(parity_err), 1);
        do_clr();
        chk("R8 clear", int'(parity_err), 0);
        par_odd = 0;
        send_char(8'h07, ($countones(8'h07) % 2) ^ 1);
        chk("R8 even parity error flagged", int'(parity_err), 1);
        do_clr(); do_read();

        // R9 overrun
        send_char(8'h05, good_par(8'h05));
        send_char(8'h3A, good_par(8'h3A));
        chk("R9 overrun flagged", int'(overrun_err), 1);
        chk("R9 newest char kept", int'(rx_char), 8'h3A);
        do_clr();
        chk("R9 clear", int'(overrun_err), 0);
        do_read();

        // R10 data char equal to sync sets flag, read clears
        do_status();
        send_char(8'h2B, good_par(8'h2B));
        chk("R10 sync char after lock", int'(sync_flag), 1);
        do_status();
        chk("R10 status read clears", int'(sync_flag), 0);
        do_read();

        // R12 hunt command in mid character
        send_bit(1); send_bit(0); send_bit(1);
        do_hunt();
        chk("R12 hunt drops lock", int'(in_hunt), 1);
        chk("R12 partial char dropped", int'(rx_ready), 0);
        send_char(8'h2B, good_par(8'h2B));
        chk("R12 realign", int'(in_hunt), 0);

        summary();
    end
endmodule